// File: doc/BRIEF.md
# Configurable Up/Down Pulse Counter with Double-Buffered Limit

This block counts edges on a primary input `s0`. A second input `s1` acts only in the quadrature mode, where it supplies the direction. The count runs between zero and a programmable limit. The limit is double-buffered: software writes a staging register, and a one-cycle command copies that value into the active limit. A second command copies the active limit into the count. This lets a counter be preset to its limit before it counts down.

The count wraps in both directions:
- Counting up past the limit returns the count to zero and raises an overflow pulse.
- Counting down from zero reloads the limit and raises an underflow pulse. The count never falls to all-ones.

A clear control acts asynchronously. While it is asserted, the count is zero and the limit sits at its default.

An optional glitch filter applies to the oversampled single-input mode. With the filter on, a level on `s0` is accepted only after it has been stable for a parameterised number of clock cycles. The whole block runs in one clock domain, and all configuration arrives already synchronised.

Top module: `edge_counter`

## Requirements
- R1: `cfgMode` selects the operating mode: 0 = idle, 1 = oversampled single-input, 2 = externally clocked single-input, 3 = quadrature. In idle mode, `s0` edges leave `cntOut` unchanged and no overflow or underflow pulse is produced.
- R2: `cfgFallEdge` selects the counted `s0` edge. When it is 0, rising edges count. When it is 1, falling edges count. An edge of the other polarity has no effect on `cntOut`.
- R3: In modes 1 and 2, `cfgCountDown` = 0 makes each counted edge add one, and `cfgCountDown` = 1 makes each counted edge subtract one.
- R4: In mode 3, `cfgCountDown` is ignored and the direction comes from `s1` at the counted edge:
  - A rising `s0` with `s1` low counts up; a rising `s0` with `s1` high counts down.
  - A falling `s0` with `s1` high counts up; a falling `s0` with `s1` low counts down.
- R5: A cycle with `topBufWrEn` high stores `topBufWrData` in the staging register and leaves `topOut` unchanged. A cycle with `cmdLoadTop` high copies the staging value present before that edge into `topOut`, visible after the edge.
- R6: A cycle with `cmdLoadCount` high copies `topOut` (as it was before the edge) into `cntOut`. It takes precedence over a count event in the same cycle.
- R7: While `cfgClear` is high, `cntOut` is 0 and `topOut` equals `TOP_RST` truncated to `CNT_W` bits, without waiting for a clock edge. The staging register keeps its value.
- R8: A count-up event with `cntOut` equal to `topOut` sets `cntOut` to 0. `overflowPulse` is high for exactly that following cycle.
- R9: A count-down event with `cntOut` equal to 0 sets `cntOut` to `topOut`. `underflowPulse` is high for exactly that following cycle.
- R10: In mode 1 with `cfgFilterEn` high, a new `s0` level is accepted only after `FILT_LEN` consecutive equal samples, so shorter pulses are not counted. Modes 2 and 3 ignore `cfgFilterEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rstN | input | 1 | Active-low asynchronous reset of the whole block |
| cfgMode | input | 2 | Operating mode (0 idle, 1 oversampled single, 2 external single, 3 quadrature) |
| cfgFallEdge | input | 1 | 1 selects falling `s0` edges, 0 selects rising |
| cfgCountDown | input | 1 | Count direction in single-input modes, 1 = down |
| cfgFilterEn | input | 1 | Enables the `s0` glitch filter in mode 1 |
| cfgClear | input | 1 | Asynchronous clear of count and limit while high |
| s0 | input | 1 | Primary pulse input |
| s1 | input | 1 | Second phase for quadrature mode |
| topBufWrEn | input | 1 | Write strobe for the staging register |
| topBufWrData | input | CNT_W | Data for the staging register |
| cmdLoadTop | input | 1 | One-cycle command: staging register to limit |
| cmdLoadCount | input | 1 | One-cycle command: limit to count |
| cntOut | output | CNT_W | Current count |
| topOut | output | CNT_W | Active limit |
| overflowPulse | output | 1 | One-cycle pulse on an upward wrap |
| underflowPulse | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The bench builds the block with `CNT_W` = 8, `FILT_LEN` = 5 and `TOP_RST` = 255, so the cleared limit fills the whole register. The bench then loads small limits such as 3. With a small limit, both wraps are reached within a few pulses, and a downward wrap to the limit is clearly distinguishable from a wrap to all-ones. With a filter length of 5, a two-cycle glitch is clearly too short and a ten-cycle pulse is clearly long enough. The same glitch is then replayed in the externally clocked mode to show that the filter is bypassed there.

// File: rtl/edge_counter_pkg.sv
package edge_counter_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE       = 2'd0,
    MODE_SAMPLED    = 2'd1,
    MODE_EXT_SINGLE = 2'd2,
    MODE_QUAD       = 2'd3
  } count_mode_e;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic countUp;
    logic countDown;
    logic loadTop;
    logic loadCnt;
  } ctl_strobe_t;

endpackage

// File: rtl/edge_counter_ctl.sv
module edge_counter_ctl
  import edge_counter_pkg::*;
#(
  parameter int unsigned FILT_LEN = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  count_mode_e mode,
  input  logic        fallEdge,
  input  logic        countDown,
  input  logic        filterEn,
  input  logic        s0,
  input  logic        s1,
  input  logic        cmdLoadTop,
  input  logic        cmdLoadCount,
  output ctl_strobe_t strobes
);

  localparam int unsigned RUN_W = $clog2(FILT_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_LEN);
  localparam logic [RUN_W-1:0] RUN_ACCEPT = RUN_W'(FILT_LEN - 2);

  logic s0Smp, s1Smp, s0Last, s0Flt, s0Prev;
  logic [RUN_W-1:0] runCnt;
  logic s0Use, riseHit, fallHit, edgeHit, upDir, active;

  // Input sampling and run-length filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0Smp  <= 1'b0;
      s1Smp  <= 1'b0;
      s0Last <= 1'b0;
      s0Flt  <= 1'b0;
      s0Prev <= 1'b0;
      runCnt <= '0;
    end else begin
      s0Smp  <= s0;
      s1Smp  <= s1;
      s0Last <= s0Smp;
      if (s0Smp != s0Last) begin
        runCnt <= '0;
      end else if (runCnt != RUN_MAX) begin
        runCnt <= runCnt + 1'b1;
      end
      if ((s0Smp == s0Last) && (runCnt >= RUN_ACCEPT)) begin
        s0Flt <= s0Smp;
      end
      s0Prev <= s0Use;
    end
  end

  always_comb begin
    s0Use   = (mode == MODE_SAMPLED && filterEn) ? s0Flt : s0Smp;
    riseHit = s0Use & ~s0Prev;
    fallHit = ~s0Use & s0Prev;
    edgeHit = fallEdge ? fallHit : riseHit;
    active  = (mode != MODE_IDLE);
    upDir   = (mode == MODE_QUAD) ? (s0Use ^ s1Smp) : ~countDown;

    strobes.countUp   = active & edgeHit & upDir;
    strobes.countDown = active & edgeHit & ~upDir;
    strobes.loadTop   = cmdLoadTop;
    strobes.loadCnt   = cmdLoadCount;
  end

endmodule

// File: rtl/edge_counter_dp.sv
module edge_counter_dp
  import edge_counter_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TOP_RST = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrN,
  input  logic             topBufWrEn,
  input  logic [CNT_W-1:0] topBufWrData,
  input  ctl_strobe_t      strobes,
  output logic [CNT_W-1:0] cntOut,
  output logic [CNT_W-1:0] topOut,
  output logic             overflowPulse,
  output logic             underflowPulse
);

  localparam logic [CNT_W-1:0] TOP_INIT = CNT_W'(TOP_RST);

  logic [CNT_W-1:0] topBuf;

  // Staging register survives the clear control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topBuf <= TOP_INIT;
    end else if (topBufWrEn) begin
      topBuf <= topBufWrData;
    end
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      cntOut         <= '0;
      topOut         <= TOP_INIT;
      overflowPulse  <= 1'b0;
      underflowPulse <= 1'b0;
    end else begin
      overflowPulse  <= 1'b0;
      underflowPulse <= 1'b0;
      if (strobes.loadTop) begin
        topOut <= topBuf;
      end
      if (strobes.loadCnt) begin
        cntOut <= topOut;
      end else if (strobes.countUp) begin
        if (cntOut == topOut) begin
          cntOut        <= '0;
          overflowPulse <= 1'b1;
        end else begin
          cntOut <= cntOut + 1'b1;
        end
      end else if (strobes.countDown) begin
        if (cntOut == '0) begin
          cntOut         <= topOut;
          underflowPulse <= 1'b1;
        end else begin
          cntOut <= cntOut - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/edge_counter.sv
module edge_counter
  import edge_counter_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned FILT_LEN = 5,
  parameter int unsigned TOP_RST  = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             cfgFallEdge,
  input  logic             cfgCountDown,
  input  logic             cfgFilterEn,
  input  logic             cfgClear,
  input  logic             s0,
  input  logic             s1,
  input  logic             topBufWrEn,
  input  logic [CNT_W-1:0] topBufWrData,
  input  logic             cmdLoadTop,
  input  logic             cmdLoadCount,
  output logic [CNT_W-1:0] cntOut,
  output logic [CNT_W-1:0] topOut,
  output logic             overflowPulse,
  output logic             underflowPulse
);

  ctl_strobe_t strobes;
  logic        clrN;

  assign clrN = rstN & ~cfgClear;

  edge_counter_ctl #(.FILT_LEN(FILT_LEN)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .mode         (count_mode_e'(cfgMode)),
    .fallEdge     (cfgFallEdge),
    .countDown    (cfgCountDown),
    .filterEn     (cfgFilterEn),
    .s0           (s0),
    .s1           (s1),
    .cmdLoadTop   (cmdLoadTop),
    .cmdLoadCount (cmdLoadCount),
    .strobes      (strobes)
  );

  edge_counter_dp #(.CNT_W(CNT_W), .TOP_RST(TOP_RST)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .clrN           (clrN),
    .topBufWrEn     (topBufWrEn),
    .topBufWrData   (topBufWrData),
    .strobes        (strobes),
    .cntOut         (cntOut),
    .topOut         (topOut),
    .overflowPulse  (overflowPulse),
    .underflowPulse (underflowPulse)
  );

endmodule

// File: rtl/edge_counter_checker.sv
module edge_counter_checker #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TOP_RST = 255
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       cfgMode,
  input logic             cfgClear,
  input logic             cmdLoadTop,
  input logic             cmdLoadCount,
  input logic [CNT_W-1:0] cntOut,
  input logic [CNT_W-1:0] topOut,
  input logic             overflowPulse,
  input logic             underflowPulse
);

  localparam logic [CNT_W-1:0] TOP_INIT = CNT_W'(TOP_RST);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    (cfgMode == 2'd0 && !cmdLoadCount) |=> $stable(cntOut)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    (cfgMode == 2'd0) |=> (!overflowPulse && !underflowPulse)); // R1
  AST_TOP_HELD: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    !cmdLoadTop |=> $stable(topOut)); // R5
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    cmdLoadCount |=> (cntOut == $past(topOut))); // R6
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rstN)
    cfgClear |-> (cntOut == '0 && topOut == TOP_INIT)); // R7
  AST_OVF_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    overflowPulse |-> (cntOut == '0)); // R8
  AST_UNF_TO_TOP: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    underflowPulse |-> (cntOut == $past(topOut))); // R9
  AST_ONE_WRAP: assert property (@(posedge clk) disable iff (!rstN || cfgClear)
    !(overflowPulse && underflowPulse)); // R8

endmodule

bind edge_counter edge_counter_checker #(.CNT_W(CNT_W), .TOP_RST(TOP_RST)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .cfgMode        (cfgMode),
  .cfgClear       (cfgClear),
  .cmdLoadTop     (cmdLoadTop),
  .cmdLoadCount   (cmdLoadCount),
  .cntOut         (cntOut),
  .topOut         (topOut),
  .overflowPulse  (overflowPulse),
  .underflowPulse (underflowPulse)
);

// File: tb/edge_counter_bench.sv
module edge_counter_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       cfgMode = 2'd0;
  logic             cfgFallEdge = 1'b0;
  logic             cfgCountDown = 1'b0;
  logic             cfgFilterEn = 1'b0;
  logic             cfgClear = 1'b0;
  logic             s0 = 1'b0;
  logic             s1 = 1'b0;
  logic             topBufWrEn = 1'b0;
  logic [CNT_W-1:0] topBufWrData = '0;
  logic             cmdLoadTop = 1'b0;
  logic             cmdLoadCount = 1'b0;
  logic [CNT_W-1:0] cntOut, topOut;
  logic             overflowPulse, underflowPulse;

  int total = 0;
  int bad = 0;
  int ovfSeen = 0;
  int unfSeen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  edge_counter #(.CNT_W(CNT_W), .FILT_LEN(5), .TOP_RST(255)) u_edge_counter (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgFallEdge(cfgFallEdge),
    .cfgCountDown(cfgCountDown), .cfgFilterEn(cfgFilterEn), .cfgClear(cfgClear),
    .s0(s0), .s1(s1), .topBufWrEn(topBufWrEn), .topBufWrData(topBufWrData),
    .cmdLoadTop(cmdLoadTop), .cmdLoadCount(cmdLoadCount), .cntOut(cntOut),
    .topOut(topOut), .overflowPulse(overflowPulse), .underflowPulse(underflowPulse)
  );

  always @(negedge clk) begin
    if (overflowPulse) ovfSeen++;
    if (underflowPulse) unfSeen++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    cfgClear = 1'b1;
    tick(1);
    cfgClear = 1'b0;
    tick(1);
  endtask

  task automatic setTop(input int v);
    topBufWrEn = 1'b1;
    topBufWrData = CNT_W'(v);
    tick(1);
    topBufWrEn = 1'b0;
    cmdLoadTop = 1'b1;
    tick(1);
    cmdLoadTop = 1'b0;
    tick(1);
  endtask

  task automatic pulse(input int h);
    s0 = 1'b1;
    tick(h);
    s0 = 1'b0;
    tick(h);
  endtask

  task automatic testReset();
    check("R7 reset count", cntOut, 0);
    check("R7 reset top", topOut, 255);
    check("R8 reset ovf", overflowPulse, 0);
  endtask

  task automatic testTopBuffer();
    topBufWrEn = 1'b1;
    topBufWrData = 8'h20;
    tick(1);
    topBufWrEn = 1'b0;
    tick(2);
    check("R5 write alone keeps top", topOut, 255);
    cmdLoadTop = 1'b1;
    tick(1);
    cmdLoadTop = 1'b0;
    check("R5 load top", topOut, 32);
    topBufWrEn = 1'b1;
    topBufWrData = 8'h40;
    cmdLoadTop = 1'b1;
    tick(1);
    topBufWrEn = 1'b0;
    cmdLoadTop = 1'b0;
    check("R5 same-cycle load uses old buffer", topOut, 32);
    cmdLoadTop = 1'b1;
    tick(1);
    cmdLoadTop = 1'b0;
    check("R5 second load", topOut, 64);
  endtask

  task automatic testLoadCount();
    clearAll();
    setTop(3);
    cmdLoadCount = 1'b1;
    tick(1);
    cmdLoadCount = 1'b0;
    check("R6 load count from top", cntOut, 3);
    // coincide load with an up-count event
    cfgMode = 2'd1;
    cfgCountDown = 1'b0;
    cfgFallEdge = 1'b0;
    setTop(5);
    s0 = 1'b1;
    tick(1);
    cmdLoadCount = 1'b1;
    tick(1);
    cmdLoadCount = 1'b0;
    s0 = 1'b0;
    tick(3);
    check("R6 load beats count event", cntOut, 5);
    cfgMode = 2'd0;
  endtask

  task automatic testUpWrap();
    int ovf0;
    clearAll();
    setTop(3);
    cfgMode = 2'd1;
    cfgCountDown = 1'b0;
    cfgFallEdge = 1'b0;
    ovf0 = ovfSeen;
    pulse(4);
    check("R3 up count one", cntOut, 1);
    repeat (4) pulse(4);
    check("R8 wrap up to zero then one", cntOut, 1);
    check("R8 one overflow pulse", ovfSeen - ovf0, 1);
    cfgMode = 2'd0;
  endtask

  task automatic testDownWrap();
    int unf0;
    clearAll();
    setTop(3);
    cfgMode = 2'd2;
    cfgCountDown = 1'b1;
    unf0 = unfSeen;
    pulse(4);
    check("R9 down from zero to top", cntOut, 3);
    check("R9 one underflow pulse", unfSeen - unf0, 1);
    pulse(4);
    check("R3 down count", cntOut, 2);
    cfgMode = 2'd0;
    cfgCountDown = 1'b0;
  endtask

  task automatic testFallEdge();
    clearAll();
    cfgMode = 2'd1;
    cfgFallEdge = 1'b1;
    s0 = 1'b1;
    tick(4);
    check("R2 rising edge ignored", cntOut, 0);
    s0 = 1'b0;
    tick(4);
    check("R2 falling edge counted", cntOut, 1);
    cfgFallEdge = 1'b0;
    cfgMode = 2'd0;
    tick(2);
  endtask

  task automatic testIdle();
    int e0;
    clearAll();
    setTop(2);
    e0 = ovfSeen + unfSeen;
    cfgMode = 2'd0;
    repeat (4) pulse(4);
    check("R1 idle holds count", cntOut, 0);
    check("R1 idle no events", ovfSeen + unfSeen - e0, 0);
  endtask

  task automatic testQuad();
    clearAll();
    cfgMode = 2'd3;
    cfgCountDown = 1'b1;
    cfgFallEdge = 1'b0;
    s1 = 1'b0;
    tick(2);
    s0 = 1'b1;
    tick(4);
    check("R4 rise with s1 low counts up", cntOut, 1);
    s0 = 1'b0;
    tick(4);
    check("R4 falling not selected", cntOut, 1);
    s1 = 1'b1;
    tick(2);
    s0 = 1'b1;
    tick(4);
    check("R4 rise with s1 high counts down", cntOut, 0);
    cfgFallEdge = 1'b1;
    tick(2);
    s0 = 1'b0;
    tick(4);
    check("R4 fall with s1 high counts up", cntOut, 1);
    s1 = 1'b0;
    cfgFallEdge = 1'b0;
    cfgCountDown = 1'b0;
    cfgMode = 2'd0;
    tick(2);
  endtask

  task automatic testFilter();
    clearAll();
    cfgMode = 2'd1;
    cfgFilterEn = 1'b1;
    tick(2);
    pulse(2);
    tick(6);
    check("R10 short glitch rejected", cntOut, 0);
    pulse(10);
    check("R10 long pulse accepted", cntOut, 1);
    cfgMode = 2'd2;
    tick(2);
    pulse(2);
    tick(2);
    check("R10 filter bypassed in mode 2", cntOut, 2);
    cfgFilterEn = 1'b0;
    cfgMode = 2'd0;
  endtask

  task automatic testClear();
    clearAll();
    setTop(7);
    cmdLoadCount = 1'b1;
    tick(1);
    cmdLoadCount = 1'b0;
    cfgClear = 1'b1;
    #2;
    check("R7 clear count async", cntOut, 0);
    check("R7 clear top async", topOut, 255);
    tick(1);
    cfgClear = 1'b0;
    tick(1);
    cmdLoadTop = 1'b1;
    tick(1);
    cmdLoadTop = 1'b0;
    check("R7 staging kept over clear", topOut, 7);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    testTopBuffer();
    testLoadCount();
    testUpWrap();
    testDownWrap();
    testFallEdge();
    testIdle();
    testQuad();
    testFilter();
    testClear();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule